// File: doc/BRIEF.md
# Locked Supply Monitor Sequencer

This block controls a supply-voltage comparator and turns a detected drop into either a reset request or an interrupt. One control register sets what a drop does, whether the comparator runs all the time or is duty-cycled, and a lock bit that freezes the register. The comparator is a digital input here. Its enable is driven by the block, and that enable is also visible as a status bit.

The control register cannot be written until a keyed unlock write has armed it. One unlock allows exactly one write. After the lock bit has been written to one, no unlock can change the register again until power-on reset. The interrupt-clear bit is the one exception: it works without an unlock and while locked.

In sampled mode a counter advances on a slow-clock tick. The comparator is powered for the first few ticks of each long period, and its output is captured only on the tick that ends the powered window.

Top module: `supmon_ctrl`

## Requirements
- R1: After rst_ni is released, the action is off, sampled mode is 0, lock is 0, the interrupt flag is 0, and on_o, rst_req_o and irq_o are all 0.
- R2: A write to the control register (offset 0) that is not armed by an unlock leaves the action, mode and lock fields unchanged.
- R3: A write to the unlock register (offset 4) arms exactly one following write to the control register. It must carry key 0xAA in wdata_i[31:24] and target offset 0 in wdata_i[3:0]. A wrong key or a wrong target does not arm. Any other read or write access in between disarms the gate.
- R4: Action field wdata_i[1:0] is encoded as 00 off, 01 reset on drop, 10 interrupt on drop, and 11 off. While the action is off, on_o, rst_req_o and irq-setting stay inactive even with below_i high.
- R5: In continuous mode (bit 4 = 0) with the action enabled, on_o is 1. below_i is captured at each clock edge. With action 01, rst_req_o is high in the cycle after a clock edge that sees below_i high.
- R6: With action 10, a captured drop sets irq_o one clock edge later. irq_o stays set after below_i falls. Any write to offset 0 with bit 8 set clears it, with no unlock needed and even when locked.
- R7: In sampled mode (bit 4 = 1), on_o is 1 for the first 4 of every 256 slow_tick_i pulses, counted from when sampled operation starts.
- R8: In sampled mode, below_i is captured only on the slow tick that ends the on-window. A drop seen at any other tick has no effect.
- R9: An accepted write with bit 7 set locks the register. Later unlocked writes then leave action, mode and lock unchanged, and only rst_ni clears the lock.
- R10: A read of offset 0 returns the action in [1:0], the mode in [4], the lock in [7], the interrupt flag in [8] and on_o in [9], with all other bits 0. A read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe; counts as an access for the unlock gate |
| addr_i | input | 4 | Register offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| slow_tick_i | input | 1 | One-cycle pulse per slow-clock period |
| below_i | input | 1 | Comparator output, 1 when the supply is under its limit |
| on_o | output | 1 | Comparator enable |
| rst_req_o | output | 1 | Reset request on drop |
| irq_o | output | 1 | Sticky drop interrupt |

## Verification
Random write sequences mix good unlocks, bad keys, wrong targets, reads placed between unlock and write, and bare writes. Read-back then shows whether the gate arms exactly once and disarms on any other access. Directed runs drive below_i in continuous mode for each action code, which separates reset, interrupt and ignored drops. In sampled mode, below_i is held high during the early on-window ticks and the long off-window, then raised on the closing tick, which shows the capture happens only at the window's end. A lock sequence followed by unlocked writes, an interrupt clear and a reset shows that the lock persists and that the clear bit bypasses it.

// File: rtl/supmon_pkg.sv
package supmon_pkg;
  typedef enum logic [1:0] {
    ACT_OFF  = 2'b00,
    ACT_RST  = 2'b01,
    ACT_IRQ  = 2'b10,
    ACT_OFF3 = 2'b11
  } act_e;

  localparam int unsigned BIT_MODE = 4;
  localparam int unsigned BIT_LOCK = 7;
  localparam int unsigned BIT_ICLR = 8;
  localparam int unsigned BIT_ON   = 9;
endpackage

// File: rtl/supmon_regs.sv
module supmon_regs
  import supmon_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter logic [7:0]  KEY      = 8'hAA,
  parameter int unsigned CTRL_OFS = 0,
  parameter int unsigned UNLK_OFS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output act_e              act_o,
  output logic              mode_o,
  output logic              lock_o,
  output logic              armed_o,
  output logic              irq_clr_o
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] UNLK_A = ADDR_W'(UNLK_OFS);

  act_e act_q;
  logic mode_q, lock_q, armed_q;
  logic hit_ctrl, hit_unlk, key_ok, accept, access;

  assign hit_ctrl = (addr_i == CTRL_A);
  assign hit_unlk = (addr_i == UNLK_A);
  assign key_ok   = (wdata_i[DATA_W-1 -: 8] == KEY) && (wdata_i[ADDR_W-1:0] == CTRL_A);
  assign access   = wr_en_i | rd_en_i;
  assign accept   = wr_en_i && hit_ctrl && armed_q && !lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
    end else if (access) begin
      armed_q <= wr_en_i && hit_unlk && key_ok;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= ACT_OFF;
      mode_q <= 1'b0;
      lock_q <= 1'b0;
    end else if (accept) begin
      act_q  <= act_e'(wdata_i[1:0]);
      mode_q <= wdata_i[BIT_MODE];
      lock_q <= wdata_i[BIT_LOCK];
    end
  end

  assign act_o     = act_q;
  assign mode_o    = mode_q;
  assign lock_o    = lock_q;
  assign armed_o   = armed_q;
  assign irq_clr_o = wr_en_i && hit_ctrl && wdata_i[BIT_ICLR];
endmodule

// File: rtl/supmon_sampler.sv
module supmon_sampler #(
  parameter int unsigned PERIOD   = 256,
  parameter int unsigned ON_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic sampled_i,
  input  logic tick_i,
  input  logic below_i,
  output logic on_o,
  output logic below_o
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST_ON  = CW'(ON_TICKS - 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;
  logic in_win, run_smp, capture;

  assign run_smp = enable_i && sampled_i;
  assign in_win  = (cnt_q < CW'(ON_TICKS));
  assign capture = run_smp && tick_i && (cnt_q == LAST_ON);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_smp) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= (cnt_q == LAST_CNT) ? '0 : cnt_q + 1'b1;
    end
  end

  // continuous: follow comparator; sampled: hold between window ends
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      below_o <= 1'b0;
    end else if (!enable_i) begin
      below_o <= 1'b0;
    end else if (!sampled_i || capture) begin
      below_o <= below_i;
    end
  end

  assign on_o = enable_i && (!sampled_i || in_win);
endmodule

// File: rtl/supmon_alarm.sv
module supmon_alarm
  import supmon_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  act_e act_i,
  input  logic below_i,
  input  logic clr_i,
  output logic rst_req_o,
  output logic irq_o
);
  logic irq_q, irq_set;

  assign irq_set = (act_i == ACT_IRQ) && below_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      irq_q <= 1'b0;
    else if (irq_set) irq_q <= 1'b1;
    else if (clr_i)   irq_q <= 1'b0;
  end

  assign rst_req_o = (act_i == ACT_RST) && below_i;
  assign irq_o     = irq_q;
endmodule

// File: rtl/supmon_ctrl.sv
module supmon_ctrl
  import supmon_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter logic [7:0]  KEY      = 8'hAA,
  parameter int unsigned CTRL_OFS = 0,
  parameter int unsigned UNLK_OFS = 4,
  parameter int unsigned PERIOD   = 256,
  parameter int unsigned ON_TICKS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              slow_tick_i,
  input  logic              below_i,
  output logic              on_o,
  output logic              rst_req_o,
  output logic              irq_o
);
  act_e act_q;
  logic mode_q, lock_q, armed_q, irq_clr, enabled, below_q;

  supmon_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY(KEY),
    .CTRL_OFS(CTRL_OFS), .UNLK_OFS(UNLK_OFS)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .act_o(act_q), .mode_o(mode_q),
    .lock_o(lock_q), .armed_o(armed_q), .irq_clr_o(irq_clr)
  );

  assign enabled = (act_q == ACT_RST) || (act_q == ACT_IRQ);

  supmon_sampler #(.PERIOD(PERIOD), .ON_TICKS(ON_TICKS)) u_smp (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enabled), .sampled_i(mode_q),
    .tick_i(slow_tick_i), .below_i(below_i), .on_o(on_o), .below_o(below_q)
  );

  supmon_alarm u_alarm (
    .clk_i(clk_i), .rst_ni(rst_ni), .act_i(act_q), .below_i(below_q),
    .clr_i(irq_clr), .rst_req_o(rst_req_o), .irq_o(irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(CTRL_OFS)) begin
      rdata_o[1:0]      = act_q;
      rdata_o[BIT_MODE] = mode_q;
      rdata_o[BIT_LOCK] = lock_q;
      rdata_o[BIT_ICLR] = irq_o;
      rdata_o[BIT_ON]   = on_o;
    end
  end
endmodule

// File: rtl/supmon_ctrl_chk.sv
module supmon_ctrl_chk #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CTRL_OFS = 0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              on_o,
  input logic              rst_req_o,
  input logic              irq_o,
  input logic [1:0]        act_q,
  input logic              mode_q,
  input logic              lock_q,
  input logic              armed_q
);
  logic en;
  assign en = (act_q == 2'b01) || (act_q == 2'b10);

  assert_unarmed_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |=> ($stable(act_q) && $stable(mode_q) && $stable(lock_q)));

  assert_off_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> (!on_o && !rst_req_o));

  assert_cont_on_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !mode_q) |-> on_o);

  assert_rst_act_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (act_q == 2'b01));

  assert_irq_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(wr_en_i && addr_i == ADDR_W'(CTRL_OFS) && wdata_i[8])) |=> irq_o);

  assert_lock_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);

  assert_lock_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> ($stable(act_q) && $stable(mode_q)));
endmodule

bind supmon_ctrl supmon_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFS(CTRL_OFS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .on_o(on_o), .rst_req_o(rst_req_o), .irq_o(irq_o),
  .act_q(act_q), .mode_q(mode_q), .lock_q(lock_q), .armed_q(armed_q)
);

// File: tb/sim_supmon_ctrl.sv
module sim_supmon_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0, below = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        on, rst_req, irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model of register state
  logic [1:0] m_act = 2'b00;
  logic       m_mode = 1'b0, m_lock = 1'b0, m_armed = 1'b0;

  localparam logic [3:0]  CTRL = 4'h0;
  localparam logic [3:0]  UNLK = 4'h4;
  localparam logic [31:0] GOOD_UNLK = 32'hAA00_0000;

  supmon_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .slow_tick_i(tick),
    .below_i(below), .on_o(on), .rst_req_o(rst_req), .irq_o(irq)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] exp_cfg(logic [1:0] a, logic md, logic lk);
    return {24'b0, lk, 2'b0, md, 2'b0, a};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; addr = '0; wdata = '0;
    if (m_armed && a == CTRL && !m_lock) begin
      m_act = d[1:0]; m_mode = d[4]; m_lock = d[7];
    end
    m_armed = (a == UNLK) && (d[31:24] == 8'hAA) && (d[3:0] == CTRL);
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 v = rdata;
    @(negedge clk); rd_en = 1'b0; addr = '0;
    m_armed = 1'b0;
  endtask

  task automatic cfg(input logic [31:0] d);
    bus_wr(UNLK, GOOD_UNLK);
    bus_wr(CTRL, d);
  endtask

  task automatic stick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R10 reset state
    bus_rd(CTRL, v);
    chk("R1 ctrl", v, 32'h0);
    chk("R1 outs", {29'b0, on, rst_req, irq}, 32'h0);

    // R2 bare write
    bus_wr(CTRL, 32'h11);
    bus_rd(CTRL, v);
    chk("R2 bare write", v, 32'h0);

    // R3 disarm on read, wrong key, wrong target
    bus_wr(UNLK, GOOD_UNLK); bus_rd(CTRL, v); bus_wr(CTRL, 32'h01);
    bus_rd(CTRL, v);
    chk("R3 read disarms", v, 32'h0);
    bus_wr(UNLK, 32'h55000000); bus_wr(CTRL, 32'h01);
    bus_rd(CTRL, v);
    chk("R3 bad key", v, 32'h0);
    bus_wr(UNLK, 32'hAA000004); bus_wr(CTRL, 32'h01);
    bus_rd(CTRL, v);
    chk("R3 bad target", v, 32'h0);
    bus_rd(UNLK, v);
    chk("R10 other offset", v, 32'h0);

    // R4 code 11 is off
    cfg(32'h03);
    bus_rd(CTRL, v);
    chk("R4 code 11 stored", v, 32'h3);
    below = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 code 11 quiet", {29'b0, on, rst_req, irq}, 32'h0);
    below = 1'b0;

    // R5 continuous reset on drop
    cfg(32'h01);
    chk("R5 on", {31'b0, on}, 32'h1);
    @(negedge clk); below = 1'b1;
    @(negedge clk);
    chk("R5 rst_req", {31'b0, rst_req}, 32'h1);
    below = 1'b0;
    @(negedge clk);
    chk("R5 rst_req release", {31'b0, rst_req}, 32'h0);

    // R6 interrupt on drop, sticky, clear without unlock
    cfg(32'h02);
    @(negedge clk); below = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R6 irq set", {31'b0, irq}, 32'h1);
    below = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 irq sticky", {31'b0, irq}, 32'h1);
    bus_rd(CTRL, v);
    chk("R10 layout", v, 32'h302);
    bus_wr(CTRL, 32'h100);
    chk("R6 irq clear", {31'b0, irq}, 32'h0);
    bus_rd(CTRL, v);
    chk("R2 clear keeps cfg", v & 32'h93, 32'h02);

    // R3 / R2 random gate traffic
    for (int i = 0; i < 150; i++) begin
      int op;
      logic [31:0] d;
      op = $urandom_range(0, 4);
      d = $urandom & 32'h13;
      case (op)
        0: bus_wr(UNLK, GOOD_UNLK);
        1: bus_wr(UNLK, {8'($urandom_range(0, 255)), 20'b0, 4'($urandom_range(0, 15))});
        2: bus_wr(4'h8, $urandom);
        3: begin bus_rd(4'h8, v); end
        default: ;
      endcase
      bus_wr(CTRL, d);
      bus_rd(CTRL, v);
      chk("R3 random gate", v & 32'h93, exp_cfg(m_act, m_mode, m_lock));
    end

    // R7 / R8 sampled mode
    cfg(32'h12);
    chk("R7 window open", {31'b0, on}, 32'h1);
    below = 1'b1;
    for (int i = 0; i < 3; i++) stick();
    chk("R7 still on", {31'b0, on}, 32'h1);
    chk("R8 early drop ignored", {31'b0, irq}, 32'h0);
    below = 1'b0;
    stick();
    chk("R7 window closed", {31'b0, on}, 32'h0);
    below = 1'b1;
    for (int i = 0; i < 251; i++) stick();
    @(negedge clk);
    chk("R8 off drop ignored", {30'b0, on, irq}, 32'h0);
    stick();
    chk("R7 window reopens", {31'b0, on}, 32'h1);
    for (int i = 0; i < 4; i++) stick();
    @(negedge clk);
    chk("R8 end capture", {30'b0, on, irq}, 32'h1);

    // R9 lock
    below = 1'b0;
    cfg(32'h80);
    bus_rd(CTRL, v);
    chk("R9 locked", v & 32'h93, 32'h80);
    bus_wr(CTRL, 32'h100);
    chk("R6 clear under lock", {31'b0, irq}, 32'h0);
    cfg(32'h01);
    bus_rd(CTRL, v);
    chk("R9 write ignored", v & 32'h93, 32'h80);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    m_act = 0; m_mode = 0; m_lock = 0; m_armed = 0;
    bus_rd(CTRL, v);
    chk("R9 reset clears lock", v, 32'h0);

    finish_run();
  end
endmodule